// File: doc/BRIEF.md
# PCI Type-0 Configuration Register File

This block holds the 256-byte configuration space of one PCI function. A host-side transaction engine gives it one access at a time. Each access has an 8-bit byte offset, a size code and, for writes, 32 bits of little-endian data. Read data comes back on the next cycle with a one-cycle valid strobe. Writes take effect at the clock edge that samples them.

Every byte written is checked against a protection map. The map is chosen by the header-type byte. The two status bytes clear the bits written as one. A full-width write to an implemented base address register stores the address bits allowed by the region's power-of-two size, plus the region's fixed type bits. The expansion-ROM register keeps its enable bit in bit 0. For each of the six base registers and the ROM register, the block drives a decode-enable and a masked base address, both taken from the command register and the stored register value. Downstream address decoders use these outputs directly.

At reset, the identity bytes, header type, region sizes and region types come from parameters. Every other byte starts at zero.

Top module: `pci_cfg_space`

## Requirements
- R1: After reset these offsets hold the parameter values: vendor ID at 0x00–0x01, device ID at 0x02–0x03, revision at 0x08, class code at 0x0A–0x0B and header type at 0x0E. The low byte of each implemented base register holds its type bits. Every other byte reads zero.
- R2: A read (req_i=1, we_i=0) raises rvalid_o for exactly the next cycle, with the data in rdata_o. A write or an idle cycle leaves rvalid_o low on the next cycle.
- R3: Size code 0 reads one byte, zero-extended. Code 1 reads two bytes little-endian, except at offset 0xFF, which returns only that byte, zero-extended. Code 2 reads the four bytes of the dword that holds the offset, ignoring offset bits 1:0.
- R4: With header type 0x00 or 0x80, byte writes to 0x00–0x03, 0x08–0x0B, 0x0E, 0x10–0x27, 0x30–0x33 and 0x3D change nothing.
- R5: With any other header type, byte writes to 0x00–0x03, 0x08–0x0B, 0x0E, 0x38–0x3B and 0x3D change nothing. The remaining offsets, 0x10–0x27 and 0x30–0x33 included, take the written byte.
- R6: A write covering offset 0x06 or 0x07 clears each status bit written as 1 and keeps every other status bit.
- R7: A size-2 write to base register n (offset 0x10+4n, n=0..5) of nonzero size S stores (data & ~(S-1)) | type bits, whatever the header type. When S is 0, the write follows the per-byte rules instead.
- R8: A size-2 write to 0x30 with a nonzero ROM size S stores (data & ~(S-1)) | data[0]. The ROM decode is enabled only when command bit 1 and stored bit 0 are both 1.
- R9: An implemented I/O region (type bit 0 = 1) is enabled when command bit 0 (offset 0x04) is 1. An implemented memory region is enabled when command bit 1 is 1. A region of size 0 is never enabled.
- R10: An enabled region's base output is its stored register value with the low log2(S) bits cleared. A disabled region's base output is zero. Both follow the stored state from the edge that commits a write.
- R11: Write sizes 1 and 2 update 2 and 4 consecutive bytes, low byte at the lowest offset. Size 2 uses the dword-aligned offset. Bytes that would land beyond 0xFF are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request for this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte offset into configuration space |
| size_i | input | 2 | 0 = byte, 1 = word, 2 = dword |
| wdata_i | input | 32 | Write data, little-endian lanes |
| rvalid_o | output | 1 | Read data valid, one cycle after a read |
| rdata_o | output | 32 | Read data |
| region_en_o | output | 7 | Decode enable per region; bit 6 is the ROM |
| region_base_o | output | 224 | Masked base address per region, 32 bits each, region 0 lowest |

## Verification
Read data and rvalid_o are due at the first rising edge after the one that samples the read. The enables and bases depend only on registered state, so they change at the edge that commits a write. The bench drives inputs on the falling edge and advances a behavioural byte-array model at each rising edge. On every falling edge it compares rvalid_o, rdata_o and all seven enable/base pairs with the model. Each result is therefore checked half a cycle after the edge that makes it due. Two instances, one with header type 0x00 and one with 0x01, get the same stimulus so that both protection maps are checked on every access.

// File: rtl/pci_cfg_pkg.sv
package pci_cfg_pkg;
  localparam int NUM_BARS    = 6;
  localparam int NUM_REGIONS = NUM_BARS + 1;
  localparam int SPACE_BYTES = 256;

  localparam logic [7:0] CMD_OFF  = 8'h04;
  localparam logic [7:0] STAT_OFF = 8'h06;
  localparam logic [7:0] HDR_OFF  = 8'h0E;
  localparam logic [7:0] BAR_OFF  = 8'h10;
  localparam logic [7:0] ROM_OFF  = 8'h30;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2
  } acc_size_e;

  function automatic logic [7:0] region_off(int r);
    return (r == NUM_BARS) ? ROM_OFF : 8'(int'(BAR_OFF) + 4 * r);
  endfunction

  // per-byte write protection, selected by header type
  function automatic logic byte_locked(logic [7:0] hdr, logic [7:0] off);
    logic fixed;
    fixed = (off <= 8'h03) || (off >= 8'h08 && off <= 8'h0B) ||
            (off == 8'h0E) || (off == 8'h3D);
    if (hdr == 8'h00 || hdr == 8'h80)
      return fixed || (off >= 8'h10 && off <= 8'h27) || (off >= 8'h30 && off <= 8'h33);
    return fixed || (off >= 8'h38 && off <= 8'h3B);
  endfunction
endpackage

// File: rtl/pci_cfg_region.sv
module pci_cfg_region #(
  parameter logic [31:0] SIZE   = 32'h0,
  parameter logic [3:0]  KIND   = 4'h0,
  parameter bit          IS_ROM = 1'b0
) (
  input  logic [31:0] bar_i,
  input  logic [1:0]  cmd_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] wval_o,
  output logic        en_o,
  output logic [31:0] base_o
);
  localparam logic [31:0] ADDR_MASK = ~(SIZE - 32'd1);
  localparam bit          IMPL      = (SIZE != 32'd0);
  localparam bit          IS_IO     = !IS_ROM && KIND[0];

  generate
    if (IS_ROM) begin : g_rom
      assign wval_o = (wdata_i & ADDR_MASK) | {31'd0, wdata_i[0]};
    end else begin : g_bar
      assign wval_o = (wdata_i & ADDR_MASK) | {28'd0, KIND};
    end
  endgenerate

  assign en_o   = IMPL && (IS_IO ? cmd_i[0] : (cmd_i[1] && (!IS_ROM || bar_i[0])));
  assign base_o = en_o ? (bar_i & ADDR_MASK) : 32'd0;
endmodule

// File: rtl/pci_cfg_rdfmt.sv
module pci_cfg_rdfmt (
  input  logic [31:0] lanes_i,
  input  logic [1:0]  size_i,
  input  logic        last_i,
  output logic [31:0] data_o
);
  always_comb begin
    unique case (size_i)
      2'd0:    data_o = {24'd0, lanes_i[7:0]};
      2'd1:    data_o = last_i ? {24'd0, lanes_i[7:0]} : {16'd0, lanes_i[15:0]};
      default: data_o = lanes_i;
    endcase
  end
endmodule

// File: rtl/pci_cfg_space.sv
module pci_cfg_space
  import pci_cfg_pkg::*;
#(
  parameter logic [15:0]            VENDOR_ID   = 16'h1D0F,
  parameter logic [15:0]            DEVICE_ID   = 16'hC0DE,
  parameter logic [7:0]             REVISION    = 8'h03,
  parameter logic [15:0]            CLASS_CODE  = 16'h0280,
  parameter logic [7:0]             HEADER_TYPE = 8'h00,
  parameter logic [NUM_BARS*32-1:0] BAR_SIZES   = {32'h0, 32'h0, 32'h0, 32'h1000, 32'h20, 32'h100},
  parameter logic [NUM_BARS*4-1:0]  BAR_KINDS   = {4'h0, 4'h0, 4'h0, 4'h8, 4'h1, 4'h0},
  parameter logic [31:0]            ROM_SIZE    = 32'h800
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      req_i,
  input  logic                      we_i,
  input  logic [7:0]                addr_i,
  input  logic [1:0]                size_i,
  input  logic [31:0]               wdata_i,
  output logic                      rvalid_o,
  output logic [31:0]               rdata_o,
  output logic [NUM_REGIONS-1:0]    region_en_o,
  output logic [NUM_REGIONS*32-1:0] region_base_o
);
  logic [7:0]             cfg_q [SPACE_BYTES];
  logic [7:0]             cfg_d [SPACE_BYTES];
  logic [31:0]            wval  [NUM_REGIONS];
  logic [NUM_REGIONS-1:0] bar_sel;
  logic [7:0]             base_a;
  logic                   wr_dw;
  logic [1:0]             cmd;
  logic [31:0]            lanes;
  logic [31:0]            rd_fmt;
  logic                   rvalid_q;
  logic [31:0]            rdata_q;

  function automatic logic [7:0] init_byte(int a);
    logic [7:0] v;
    v = 8'h00;
    case (a)
      0:  v = VENDOR_ID[7:0];
      1:  v = VENDOR_ID[15:8];
      2:  v = DEVICE_ID[7:0];
      3:  v = DEVICE_ID[15:8];
      8:  v = REVISION;
      10: v = CLASS_CODE[7:0];
      11: v = CLASS_CODE[15:8];
      14: v = HEADER_TYPE;
      default: ;
    endcase
    for (int r = 0; r < NUM_BARS; r++)
      if (a == int'(region_off(r)) && BAR_SIZES[r*32 +: 32] != 32'd0)
        v = {4'h0, BAR_KINDS[r*4 +: 4]};
    return v;
  endfunction

  assign wr_dw  = size_i[1];
  assign base_a = wr_dw ? {addr_i[7:2], 2'b00} : addr_i;
  assign cmd    = cfg_q[CMD_OFF][1:0];

  generate
    for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
      localparam logic [7:0] OFF = region_off(r);
      logic [31:0] bar;
      assign bar = {cfg_q[OFF + 8'd3], cfg_q[OFF + 8'd2], cfg_q[OFF + 8'd1], cfg_q[OFF]};
      if (r < NUM_BARS) begin : g_bar
        assign bar_sel[r] = wr_dw && (base_a == OFF) && (BAR_SIZES[r*32 +: 32] != 32'd0);
        pci_cfg_region #(
          .SIZE  (BAR_SIZES[r*32 +: 32]),
          .KIND  (BAR_KINDS[r*4 +: 4]),
          .IS_ROM(1'b0)
        ) u_region (
          .bar_i  (bar),
          .cmd_i  (cmd),
          .wdata_i(wdata_i),
          .wval_o (wval[r]),
          .en_o   (region_en_o[r]),
          .base_o (region_base_o[r*32 +: 32])
        );
      end else begin : g_rom
        assign bar_sel[r] = wr_dw && (base_a == OFF) && (ROM_SIZE != 32'd0);
        pci_cfg_region #(
          .SIZE  (ROM_SIZE),
          .KIND  (4'h0),
          .IS_ROM(1'b1)
        ) u_region (
          .bar_i  (bar),
          .cmd_i  (cmd),
          .wdata_i(wdata_i),
          .wval_o (wval[r]),
          .en_o   (region_en_o[r]),
          .base_o (region_base_o[r*32 +: 32])
        );
      end
    end
  endgenerate

  // next state of the byte array for a write this cycle
  always_comb begin
    logic [8:0] pos;
    logic [7:0] off;
    logic [7:0] wb;
    int         nbytes;
    cfg_d  = cfg_q;
    pos    = '0;
    off    = '0;
    wb     = '0;
    nbytes = wr_dw ? 4 : (size_i[0] ? 2 : 1);
    if (|bar_sel) begin
      for (int r = 0; r < NUM_REGIONS; r++)
        if (bar_sel[r])
          for (int k = 0; k < 4; k++)
            cfg_d[region_off(r) + 8'(k)] = wval[r][k*8 +: 8];
    end else begin
      for (int k = 0; k < 4; k++) begin
        pos = {1'b0, base_a} + 9'(k);
        off = pos[7:0];
        wb  = wdata_i[k*8 +: 8];
        if (k < nbytes && !pos[8]) begin
          if (off == STAT_OFF || off == STAT_OFF + 8'd1)
            cfg_d[off] = cfg_q[off] & ~wb;
          else if (!byte_locked(cfg_q[HDR_OFF], off))
            cfg_d[off] = wb;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < SPACE_BYTES; i++) cfg_q[i] <= init_byte(i);
    end else if (req_i && we_i) begin
      cfg_q <= cfg_d;
    end
  end

  always_comb begin
    for (int k = 0; k < 4; k++) lanes[k*8 +: 8] = cfg_q[base_a + 8'(k)];
  end

  pci_cfg_rdfmt u_rdfmt (
    .lanes_i(lanes),
    .size_i (size_i),
    .last_i (addr_i == 8'hFF),
    .data_o (rd_fmt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= req_i && !we_i;
      if (req_i && !we_i) rdata_q <= rd_fmt;
    end
  end

  assign rvalid_o = rvalid_q;
  assign rdata_o  = rdata_q;
endmodule

// File: rtl/pci_cfg_space_chk.sv
module pci_cfg_space_chk
  import pci_cfg_pkg::*;
(
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      req_i,
  input logic                      we_i,
  input logic [7:0]                addr_i,
  input logic [1:0]                size_i,
  input logic                      rvalid_o,
  input logic [31:0]               rdata_o,
  input logic [NUM_REGIONS-1:0]    region_en_o,
  input logic [NUM_REGIONS*32-1:0] region_base_o,
  input logic [1:0]                cmd_i
);
  // R2
  read_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> rvalid_o);

  // R2
  no_read_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> !rvalid_o);

  // R3
  byte_read_zext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && size_i == 2'd0) |=> (rdata_o[31:8] == 24'd0));

  // R3
  top_word_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && size_i == 2'd1 && addr_i == 8'hFF) |=> (rdata_o[31:8] == 24'd0));

  // R9
  cmd_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 2'b00) |-> (region_en_o == '0));

  generate
    for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_chk
      // R10
      base_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !region_en_o[r] |-> (region_base_o[r*32 +: 32] == 32'd0));
      // R10
      base_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        region_en_o[r] |-> (region_base_o[r*32 +: 2] == 2'b00));
    end
  endgenerate
endmodule

bind pci_cfg_space pci_cfg_space_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_i        (req_i),
  .we_i         (we_i),
  .addr_i       (addr_i),
  .size_i       (size_i),
  .rvalid_o     (rvalid_o),
  .rdata_o      (rdata_o),
  .region_en_o  (region_en_o),
  .region_base_o(region_base_o),
  .cmd_i        (cmd)
);

// File: tb/pci_cfg_space_tb.sv
`timescale 1ns/1ps
module pci_cfg_space_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [1:0]  size = 2'd0;
  logic [31:0] wdata = 32'h0;

  logic        rv [2];
  logic [31:0] rd [2];
  logic [6:0]  en [2];
  logic [223:0] bs [2];

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0]  mdl [2][256];
  logic        exp_rv = 1'b0;
  logic [31:0] exp_rd [2];
  string       cur_tag = "";
  string       rd_tag = "";

  always #10 clk = ~clk;

  pci_cfg_space #(.HEADER_TYPE(8'h00)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .size_i(size), .wdata_i(wdata), .rvalid_o(rv[0]), .rdata_o(rd[0]),
    .region_en_o(en[0]), .region_base_o(bs[0]));

  pci_cfg_space #(.HEADER_TYPE(8'h01)) u_dut_b (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .size_i(size), .wdata_i(wdata), .rvalid_o(rv[1]), .rdata_o(rd[1]),
    .region_en_o(en[1]), .region_base_o(bs[1]));

  function automatic int hdr_of(int d);
    return (d == 0) ? 0 : 1;
  endfunction

  function automatic logic [31:0] rsize(int r);
    case (r)
      0: return 32'd256;
      1: return 32'd32;
      2: return 32'd4096;
      6: return 32'd2048;
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic [31:0] rkind(int r);
    case (r)
      1: return 32'd1;
      2: return 32'd8;
      default: return 32'd0;
    endcase
  endfunction

  function automatic int roff(int r);
    return (r == 6) ? 48 : 16 + 4 * r;
  endfunction

  function automatic bit locked(int hdr, int a);
    bit c;
    c = (a < 4) || (a >= 8 && a < 12) || a == 14 || a == 61;
    if (hdr == 0 || hdr == 128) return c || (a >= 16 && a < 40) || (a >= 48 && a < 52);
    return c || (a >= 56 && a < 60);
  endfunction

  task automatic mdl_reset();
    for (int d = 0; d < 2; d++) begin
      for (int a = 0; a < 256; a++) mdl[d][a] = 8'h00;
      mdl[d][0] = 8'h0F; mdl[d][1] = 8'h1D; mdl[d][2] = 8'hDE; mdl[d][3] = 8'hC0;
      mdl[d][8] = 8'h03; mdl[d][10] = 8'h80; mdl[d][11] = 8'h02;
      mdl[d][14] = 8'(hdr_of(d));
      for (int r = 0; r < 6; r++)
        if (rsize(r) != 0) mdl[d][roff(r)] = rkind(r)[7:0];
    end
  endtask

  task automatic mdl_write(int d, int a, int sz, logic [31:0] data);
    int hit;
    logic [31:0] v;
    hit = -1;
    if (sz >= 2) a = a & 252;
    if (sz >= 2)
      for (int r = 0; r < 7; r++)
        if (roff(r) == a && rsize(r) != 0) hit = r;
    if (hit >= 0) begin
      v = data & ~(rsize(hit) - 1);
      v = v | ((hit == 6) ? (data & 32'd1) : rkind(hit));
      for (int k = 0; k < 4; k++) mdl[d][a + k] = v[k*8 +: 8];
    end else begin
      for (int k = 0; k < ((sz >= 2) ? 4 : sz + 1); k++) begin
        int p;
        logic [7:0] b;
        p = a + k;
        b = data[k*8 +: 8];
        if (p < 256) begin
          if (p == 6 || p == 7) mdl[d][p] = mdl[d][p] & ~b;
          else if (!locked(hdr_of(d), p)) mdl[d][p] = b;
        end
      end
    end
  endtask

  function automatic logic [31:0] mdl_read(int d, int a, int sz);
    if (sz == 0) return {24'd0, mdl[d][a]};
    if (sz == 1) return (a == 255) ? {24'd0, mdl[d][a]} : {16'd0, mdl[d][a + 1], mdl[d][a]};
    a = a & 252;
    return {mdl[d][a + 3], mdl[d][a + 2], mdl[d][a + 1], mdl[d][a]};
  endfunction

  task automatic chk(bit ok, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act %h exp %h", what, act, exp);
    end
  endtask

  // reference model advances at each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      mdl_reset();
      exp_rv = 1'b0;
    end else begin
      exp_rv = req && !we;
      if (req) begin
        for (int d = 0; d < 2; d++)
          if (we) mdl_write(d, int'(addr), int'(size), wdata);
          else exp_rd[d] = mdl_read(d, int'(addr), int'(size));
        if (!we) rd_tag = cur_tag;
      end
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int d = 0; d < 2; d++) begin
        chk(rv[d] === exp_rv, $sformatf("R2 dut%0d rvalid", d), {31'd0, rv[d]}, {31'd0, exp_rv});
        if (exp_rv)
          chk(rd[d] === exp_rd[d], $sformatf("%s dut%0d rdata", rd_tag, d), rd[d], exp_rd[d]);
        for (int r = 0; r < 7; r++) begin
          logic [31:0] bar;
          logic [7:0]  cmdb;
          bit          e;
          logic [31:0] b;
          bar  = {mdl[d][roff(r) + 3], mdl[d][roff(r) + 2], mdl[d][roff(r) + 1], mdl[d][roff(r)]};
          cmdb = mdl[d][4];
          if (rsize(r) == 0) e = 1'b0;
          else if (r == 6) e = cmdb[1] && bar[0];
          else if (rkind(r)[0]) e = cmdb[0];
          else e = cmdb[1];
          b = e ? (bar & ~(rsize(r) - 1)) : 32'd0;
          chk(en[d][r] === e, $sformatf("%s dut%0d region%0d enable", (r == 6) ? "R8" : "R9", d, r),
              {31'd0, en[d][r]}, {31'd0, e});
          chk(bs[d][r*32 +: 32] === b, $sformatf("R10 dut%0d region%0d base", d, r), bs[d][r*32 +: 32], b);
        end
      end
    end
  end

  task automatic acc(bit w, logic [7:0] a, logic [1:0] s, logic [31:0] d, string t);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; size = s; wdata = d; cur_tag = t;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset contents
    acc(0, 8'h00, 2'd2, 0, "R1");
    acc(0, 8'h08, 2'd0, 0, "R1");
    acc(0, 8'h0A, 2'd1, 0, "R1");
    acc(0, 8'h0E, 2'd0, 0, "R1");
    acc(0, 8'h14, 2'd2, 0, "R1");
    acc(0, 8'h18, 2'd2, 0, "R1");
    acc(0, 8'h40, 2'd2, 0, "R1");

    // R3 read sizes, including the top word and an unaligned dword
    acc(0, 8'h01, 2'd0, 0, "R3");
    acc(0, 8'h02, 2'd1, 0, "R3");
    acc(0, 8'h03, 2'd2, 0, "R3");
    acc(1, 8'hFF, 2'd0, 32'h0000_00A5, "R11");
    acc(0, 8'hFF, 2'd1, 0, "R3");
    acc(0, 8'hFE, 2'd1, 0, "R3");

    // R11 little-endian split, aligned dword, dropped bytes past the top
    acc(1, 8'h40, 2'd1, 32'h0000_BEEF, "R11");
    acc(0, 8'h40, 2'd0, 0, "R11");
    acc(0, 8'h41, 2'd0, 0, "R11");
    acc(1, 8'h47, 2'd2, 32'h1122_3344, "R11");
    acc(0, 8'h44, 2'd2, 0, "R11");
    acc(1, 8'hFF, 2'd1, 32'h0000_5A3C, "R11");
    acc(0, 8'hFF, 2'd0, 0, "R11");

    // R4 and R5 protection maps
    acc(1, 8'h00, 2'd2, 32'hFFFF_FFFF, "R4");
    acc(0, 8'h00, 2'd2, 0, "R4");
    acc(1, 8'h0E, 2'd0, 32'h0000_00FF, "R4");
    acc(0, 8'h0C, 2'd2, 0, "R5");
    acc(1, 8'h3D, 2'd0, 32'h0000_0077, "R4");
    acc(1, 8'h3C, 2'd0, 32'h0000_000B, "R5");
    acc(0, 8'h3C, 2'd2, 0, "R5");
    acc(1, 8'h20, 2'd1, 32'h0000_ABCD, "R5");
    acc(0, 8'h20, 2'd2, 0, "R5");
    acc(1, 8'h31, 2'd0, 32'h0000_0066, "R5");
    acc(0, 8'h30, 2'd2, 0, "R4");
    acc(1, 8'h39, 2'd0, 32'h0000_0099, "R5");
    acc(0, 8'h38, 2'd2, 0, "R4");
    acc(1, 8'h10, 2'd1, 32'h0000_FFFF, "R4");
    acc(0, 8'h10, 2'd2, 0, "R4");

    // R6 status clears on ones
    acc(1, 8'h06, 2'd1, 32'h0000_FFFF, "R6");
    acc(0, 8'h06, 2'd1, 0, "R6");
    acc(1, 8'h04, 2'd2, 32'hFFFF_0000, "R6");
    acc(0, 8'h04, 2'd2, 0, "R6");

    // R7 base register masking
    acc(1, 8'h10, 2'd2, 32'hFFFF_FFFF, "R7");
    acc(0, 8'h10, 2'd2, 0, "R7");
    acc(1, 8'h14, 2'd2, 32'hFFFF_FFFF, "R7");
    acc(0, 8'h14, 2'd2, 0, "R7");
    acc(1, 8'h18, 2'd2, 32'hCAFE_1234, "R7");
    acc(0, 8'h18, 2'd2, 0, "R7");
    acc(1, 8'h1C, 2'd2, 32'h8765_4321, "R7");
    acc(0, 8'h1C, 2'd2, 0, "R7");

    // R8 ROM register
    acc(1, 8'h30, 2'd2, 32'hFFFF_FFFE, "R8");
    acc(0, 8'h30, 2'd2, 0, "R8");
    acc(1, 8'h04, 2'd0, 32'h0000_0002, "R8");
    acc(1, 8'h30, 2'd2, 32'h1234_5FFF, "R8");
    acc(0, 8'h30, 2'd2, 0, "R8");

    // R9 and R10 command decode and bases
    acc(1, 8'h04, 2'd0, 32'h0000_0001, "R9");
    acc(1, 8'h14, 2'd2, 32'h0000_C0E7, "R10");
    acc(1, 8'h04, 2'd0, 32'h0000_0003, "R9");
    acc(1, 8'h10, 2'd2, 32'hF000_01FF, "R10");
    acc(1, 8'h04, 2'd1, 32'h0000_0000, "R9");
    acc(1, 8'h04, 2'd2, 32'h0000_0002, "R9");
    acc(0, 8'h04, 2'd0, 0, "R9");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule